// File: doc/BRIEF.md
# Palette and Pixel Format Unit

This unit sits between the framebuffer fetch path and the display output of a graphics controller. Each cycle it may accept one fetched pixel word, tagged by a valid flag, and turns it into a 24-bit RGB colour under the current display mode. Three formats are handled: an 8-bit indexed format that looks the colour up in a 256-entry palette, a 16-bit 5-6-5 format whose components are widened to 8 bits, and a 24-bit format carried in 32-bit words.

In the 24-bit format a bypass bit selects the path. When it is set, the three components go straight to the output. When it is clear, each component is used as its own palette index and only the matching channel of that entry is kept, so the palette acts as a per-channel gamma or correction table.

Software loads the palette through an indirect pair of registers: it writes an entry number to the index register, then writes colours to the data register. Each data write advances the index, so a whole table is loaded with one index write and a stream of data writes. The converted colour leaves on a register one cycle after the pixel enters, with its valid flag delayed to match.

Top module: `pxfmt_palette_unit`

## Requirements
- R1: Synchronous reset clears `out_valid` and `out_rgb` to zero and sets the palette index to 0, so the first data write after reset lands in entry 0.
- R2: A register write with `reg_sel`=0 loads the palette index from `reg_wdata[7:0]`; `reg_wdata[31:8]` is ignored.
- R3: A register write with `reg_sel`=1 stores `reg_wdata[23:0]` into the entry named by the index, red in [23:16], green in [15:8], blue in [7:0]; `reg_wdata[31:24]` is ignored. The new contents are visible to a pixel accepted in the next cycle.
- R4: Each data write advances the index by one, wrapping from 255 to 0.
- R5: With `mode`=0 (8-bit indexed), `pix_data[7:0]` selects a palette entry and the output is that whole entry; `pix_data[31:8]` is ignored.
- R6: With `mode`=1 (16-bit), `pix_data[15:0]` holds red [15:11], green [10:5], blue [4:0]; each component is widened to 8 bits by placing it in the top bits and repeating its most significant bits in the low bits; `pix_data[31:16]` is ignored.
- R7: With `mode`=2 and `pal_bypass`=1, the output equals `pix_data[23:0]`; `pix_data[31:24]` is ignored.
- R8: With `mode`=2 and `pal_bypass`=0, output red is the red channel of entry `pix_data[23:16]`, green the green channel of entry `pix_data[15:8]`, blue the blue channel of entry `pix_data[7:0]`.
- R9: `pal_bypass` has no effect in modes 0 and 1.
- R10: `mode`=3 is reserved and gives an all-zero colour, still flagged valid.
- R11: `out_valid` equals `pix_valid` of the previous cycle, and `out_rgb` is updated on that same edge.
- R12: While `pix_valid` is low, `out_rgb` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel word present |
| pix_data | input | 32 | Fetched pixel word |
| mode | input | 2 | Pixel format: 0 indexed 8-bit, 1 5-6-5, 2 24-bit, 3 reserved |
| pal_bypass | input | 1 | In 24-bit format, skip the palette |
| reg_wr | input | 1 | Palette register write strobe |
| reg_sel | input | 1 | 0 selects the index register, 1 the data register |
| reg_wdata | input | 32 | Palette register write data |
| out_valid | output | 1 | Output colour present |
| out_rgb | output | 24 | Output colour, red [23:16], green [15:8], blue [7:0] |

## Verification
A wrong palette index shows up as a colour taken from the wrong entry on the first pixel that looks up the entry just written, one cycle after that pixel enters; the bench writes distinct values per entry so a slip of one slot is visible. A stuck or mis-selected format path shows at the output register on the very next cycle, since every mode is combinational up to that register. A lost wrap of the index only appears after 256 data writes, so the bench writes one entry past the end and reads entry 0 back.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;

    localparam int COMP_W  = 8;
    localparam int IDX_W   = 8;
    localparam int PAL_N   = 1 << IDX_W;
    localparam int WORD_W  = 32;
    localparam int RGB_W   = 3 * COMP_W;

    typedef enum logic [1:0] {
        MODE_IDX8   = 2'd0,
        MODE_RGB565 = 2'd1,
        MODE_RGB24  = 2'd2,
        MODE_RSVD   = 2'd3
    } pix_mode_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    // Widen a component by repeating its upper bits below it.
    function automatic logic [7:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    function automatic rgb_t from565(input logic [15:0] w);
        rgb_t c;
        c.r = widen5(w[15:11]);
        c.g = widen6(w[10:5]);
        c.b = widen5(w[4:0]);
        return c;
    endfunction

endpackage

// File: rtl/pxfmt_palregs.sv
module pxfmt_palregs
    import pxfmt_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic          wr_en,
    output logic [IW-1:0] wr_addr,
    output rgb_t          wr_color
);

    logic [IW-1:0] idx_q;
    logic [DW-1:0] unused_wdata;

    assign unused_wdata = reg_wdata;
    assign wr_en        = reg_wr && reg_sel;
    assign wr_addr      = idx_q;
    assign wr_color     = rgb_t'(reg_wdata[RGB_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (reg_wr) begin
            if (!reg_sel) idx_q <= reg_wdata[IW-1:0];
            else          idx_q <= idx_q + 1'b1;
        end
    end

    // R2: index register load
    a_r2_index_load: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel) |=> (idx_q == $past(reg_wdata[IW-1:0])));

    // R4: advance after each data write, wrapping naturally
    a_r4_autoinc: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel) |=> (idx_q == IW'($past(idx_q) + 1)));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(idx_q));

endmodule

// File: rtl/pxfmt_palram.sv
module pxfmt_palram
    import pxfmt_pkg::*;
#(
    parameter int IW  = IDX_W,
    parameter int NRD = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_addr,
    input  rgb_t                    wr_color,
    input  logic [NRD-1:0][IW-1:0]  rd_addr,
    output rgb_t [NRD-1:0]          rd_data
);

    localparam int DEPTH = 1 << IW;

    rgb_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_color;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem[rd_addr[p]];
    end

    // R3: a data write lands in the addressed entry
    a_r3_store: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_color)));

endmodule

// File: rtl/pxfmt_decode.sv
module pxfmt_decode
    import pxfmt_pkg::*;
#(
    parameter int IW  = IDX_W,
    parameter int DW  = WORD_W,
    parameter int NRD = 3
) (
    input  logic [1:0]              mode,
    input  logic                    pal_bypass,
    input  logic [DW-1:0]           pix_data,
    output logic [NRD-1:0][IW-1:0]  rd_addr,
    input  rgb_t [NRD-1:0]          rd_data,
    output rgb_t                    pix_rgb
);

    // Port 0 serves red, port 1 green, port 2 blue and the whole 8-bit lookup.
    localparam int P_R = 0;
    localparam int P_G = 1;
    localparam int P_B = NRD - 1;

    rgb_t direct24;
    rgb_t gamma24;
    rgb_t unpk565;
    logic [DW-1:0] unused_pix;

    assign unused_pix = pix_data;

    assign rd_addr[P_R] = pix_data[2*COMP_W +: IW];
    assign rd_addr[P_G] = pix_data[COMP_W   +: IW];
    assign rd_addr[P_B] = pix_data[0        +: IW];

    assign direct24  = rgb_t'(pix_data[RGB_W-1:0]);
    assign unpk565   = from565(pix_data[15:0]);

    always_comb begin
        gamma24   = '0;
        gamma24.r = rd_data[P_R].r;
        gamma24.g = rd_data[P_G].g;
        gamma24.b = rd_data[P_B].b;
    end

    always_comb begin
        case (pix_mode_e'(mode))
            MODE_IDX8:   pix_rgb = rd_data[P_B];
            MODE_RGB565: pix_rgb = unpk565;
            MODE_RGB24:  pix_rgb = pal_bypass ? direct24 : gamma24;
            default:     pix_rgb = '0;
        endcase
    end

endmodule

// File: rtl/pxfmt_palette_unit.sv
module pxfmt_palette_unit
    import pxfmt_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int DW = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    input  logic [DW-1:0]     pix_data,
    input  logic [1:0]        mode,
    input  logic              pal_bypass,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DW-1:0]     reg_wdata,
    output logic              out_valid,
    output logic [RGB_W-1:0]  out_rgb
);

    localparam int NRD = 3;

    logic                   pw_en;
    logic [IW-1:0]          pw_addr;
    rgb_t                   pw_color;
    logic [NRD-1:0][IW-1:0] pr_addr;
    rgb_t [NRD-1:0]         pr_data;
    rgb_t                   pix_rgb;

    pxfmt_palregs #(.IW(IW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .wr_en    (pw_en),
        .wr_addr  (pw_addr),
        .wr_color (pw_color)
    );

    pxfmt_palram #(.IW(IW), .NRD(NRD)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pw_en),
        .wr_addr (pw_addr),
        .wr_color(pw_color),
        .rd_addr (pr_addr),
        .rd_data (pr_data)
    );

    pxfmt_decode #(.IW(IW), .DW(DW), .NRD(NRD)) u_dec (
        .mode      (mode),
        .pal_bypass(pal_bypass),
        .pix_data  (pix_data),
        .rd_addr   (pr_addr),
        .rd_data   (pr_data),
        .pix_rgb   (pix_rgb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= pix_valid;
            if (pix_valid) out_rgb <= pix_rgb;
        end
    end

    // R11: valid follows the input one cycle later
    a_r11_valid_on: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);
    a_r11_valid_off: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid);

    // R12: colour holds across idle cycles
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> $stable(out_rgb));

    // R7: bypass passes components through
    a_r7_bypass: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && mode == 2'd2 && pal_bypass)
            |=> (out_rgb == $past(pix_data[RGB_W-1:0])));

    // R6: component top bits come straight from the 5-6-5 fields
    a_r6_565_top: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && mode == 2'd1)
            |=> (out_rgb[23:19] == $past(pix_data[15:11]) &&
                 out_rgb[15:10] == $past(pix_data[10:5])  &&
                 out_rgb[7:3]   == $past(pix_data[4:0])));

    // R10: reserved mode yields black
    a_r10_reserved: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && mode == 2'd3) |=> (out_rgb == '0));

endmodule

// File: tb/test_pxfmt_palette_unit.sv
`timescale 1ns/1ps
module test_pxfmt_palette_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        pix_valid;
    logic [31:0] pix_data;
    logic [1:0]  mode;
    logic        pal_bypass;
    logic        reg_wr;
    logic        reg_sel;
    logic [31:0] reg_wdata;
    logic        out_valid;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pxfmt_palette_unit i_pxfmt_palette_unit (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .mode      (mode),
        .pal_bypass(pal_bypass),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .out_valid (out_valid),
        .out_rgb   (out_rgb)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic        byp;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 32'hFFFF_FF00, 8'd5},   // R5 upper bits ignored
        '{2'd0, 1'b1, 32'h0000_0037, 8'd9},   // R9 bypass no effect, indexed
        '{2'd0, 1'b0, 32'h0000_00A5, 8'd5},   // R5
        '{2'd1, 1'b0, 32'h0000_F800, 8'd6},   // R6 red full scale
        '{2'd1, 1'b1, 32'hFFFF_07E0, 8'd9},   // R9 bypass no effect, 5-6-5
        '{2'd1, 1'b0, 32'h0000_1234, 8'd6},   // R6
        '{2'd2, 1'b1, 32'hAA12_3456, 8'd7},   // R7 top byte ignored
        '{2'd2, 1'b1, 32'h00FF_FFFF, 8'd7},   // R7
        '{2'd2, 1'b0, 32'h0010_2030, 8'd8},   // R8 per-channel lookup
        '{2'd2, 1'b0, 32'h77FF_0001, 8'd8},   // R8
        '{2'd3, 1'b0, 32'h1234_5678, 8'd10},  // R10 reserved
        '{2'd3, 1'b1, 32'hFFFF_FFFF, 8'd10}   // R10
    };

    // Bench palette pattern: distinct per entry in every channel.
    function automatic logic [23:0] palv(input logic [7:0] i);
        return {i, ~i, i ^ 8'h5A};
    endfunction

    function automatic logic [23:0] model(input logic [1:0] md, input logic byp,
                                          input logic [31:0] d);
        logic [23:0] a, b, c;
        case (md)
            2'd0: return palv(d[7:0]);
            2'd1: return {d[15:11], d[15:13], d[10:5], d[10:9], d[4:0], d[4:2]};
            2'd2: begin
                if (byp) return d[23:0];
                a = palv(d[23:16]);
                b = palv(d[15:8]);
                c = palv(d[7:0]);
                return {a[23:16], b[15:8], c[7:0]};
            end
            default: return 24'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns after the next one.
    task automatic reg_write(input logic sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pixel(input logic [1:0] md, input logic byp, input logic [31:0] d);
        pix_valid = 1'b1; mode = md; pal_bypass = byp; pix_data = d;
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] held;
        rst = 1'b1; pix_valid = 1'b0; pix_data = '0; mode = '0; pal_bypass = 1'b0;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 out_rgb", 32'(out_rgb), 32'd0);

        // R1: first data write after reset goes to entry 0
        reg_write(1'b1, 32'h00AB_CDEF);
        pixel(2'd0, 1'b0, 32'h0);
        check("R1 index zero", 32'(out_rgb), 32'h00AB_CDEF);
        check("R11 valid", 32'(out_valid), 32'd1);
        @(negedge clk);
        check("R11 valid drop", 32'(out_valid), 32'd0);

        // R4: load the whole table from entry 0 with auto-increment
        reg_write(1'b0, 32'h0);
        for (int i = 0; i < 256; i++) reg_write(1'b1, {8'h00, palv(8'(i))});
        // R4: the index has wrapped to 0
        reg_write(1'b1, 32'h00C0_FFEE);
        pixel(2'd0, 1'b0, 32'h0);
        check("R4 wrap", 32'(out_rgb), 32'h00C0_FFEE);
        pixel(2'd0, 1'b0, 32'hFF);
        check("R4 last entry", 32'(out_rgb), 32'(palv(8'hFF)));
        reg_write(1'b0, 32'h0);
        reg_write(1'b1, {8'h00, palv(8'h00)});

        // R2 and R3: upper bits of both registers ignored
        reg_write(1'b0, 32'hFFFF_FF40);
        reg_write(1'b1, 32'hAB11_2233);
        pixel(2'd0, 1'b0, 32'h40);
        check("R2 R3 store", 32'(out_rgb), 32'h0011_2233);
        // R4: next data write landed in entry 0x41
        reg_write(1'b1, 32'h0044_5566);
        pixel(2'd0, 1'b0, 32'h41);
        check("R4 advance", 32'(out_rgb), 32'h0044_5566);
        reg_write(1'b0, 32'h40);
        reg_write(1'b1, {8'h00, palv(8'h40)});
        reg_write(1'b1, {8'h00, palv(8'h41)});

        // Table walk: R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            pixel(VECS[v].md, VECS[v].byp, VECS[v].data);
            checks++;
            if (out_rgb !== model(VECS[v].md, VECS[v].byp, VECS[v].data) || out_valid !== 1'b1) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual %h valid %b expected %h", VECS[v].req, v,
                         out_rgb, out_valid, model(VECS[v].md, VECS[v].byp, VECS[v].data));
            end
        end

        // R12: idle cycles with changing data leave the colour unchanged
        pixel(2'd2, 1'b1, 32'h0013_5779);
        held = out_rgb;
        check("R7 direct", 32'(held), 32'h0013_5779);
        pix_data = 32'h00FF_0000; mode = 2'd1;
        @(negedge clk);
        check("R12 hold", 32'(out_rgb), 32'(held));
        check("R12 valid low", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R12 hold again", 32'(out_rgb), 32'(held));

        // R11: back-to-back pixels each appear one cycle later
        pix_valid = 1'b1; mode = 2'd2; pal_bypass = 1'b1; pix_data = 32'h0000_0001;
        @(negedge clk);
        check("R11 first", 32'(out_rgb), 32'h0000_0001);
        pix_data = 32'h0000_0002;
        @(negedge clk);
        check("R11 second", 32'(out_rgb), 32'h0000_0002);
        pix_valid = 1'b0;

        // R1: reset mid-stream clears output
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset again", 32'({out_valid, out_rgb}), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule